// File: doc/BRIEF.md
# Interlaced Field Tracking Generator

This block keeps the raster position of a 625-line interlaced video encoder and derives from it a registered field indicator. A pixel counter and a line counter advance on every pixel clock. The indicator marks whether the raster is in the first (odd) field or the second (even) field, and a control input can invert its sense.

As timing master, the block produces its own active-low horizontal and vertical sync pulses from the counters and ignores the sync inputs. As timing slave, it watches incoming horizontal/vertical sync pairs. After a reset it sits at the start of the odd field. The first pair moves it to the start of the even field, and the second pair produces an internal frame sync that returns it to the start of the odd field. This alternation repeats.

When the source is progressive, there is no field information in the input. The block then counts input frames, and every second pair is a frame sync that forces the odd field.

Top module: `fld_track_gen`

## Requirements
- R1: `field_o` equals (raster is in the even field) XOR `fld_pol`, using the value of `fld_pol` at the clock edge that updates the counters. With `fld_pol` = 0, `field_o` is 1 in the even field and 0 in the odd field.
- R2: `pix_cnt` runs from 1 to LINE_PIXELS and then wraps to 1. `line_cnt` increments when `pix_cnt` wraps, and it runs from 1 to FRAME_LINES and then wraps to 1.
- R3: When `rst` (synchronous) or `soft_rst` (a one-cycle strobe) is sampled high at a clock edge, that edge sets `line_cnt`=1 and `pix_cnt`=1, and the raster is in the odd field. A soft reset takes priority over a sync pair sampled at the same edge.
- R4: The even field covers lines FIELD2_LINE through FRAME_LINES. The odd field covers lines 1 through FIELD2_LINE-1. `field_o` changes in the same cycle that `line_cnt` enters a field.
- R5: In master mode (`slave_mode`=0), `hsync_o_n` is low while `pix_cnt` is at most HS_WIDTH. `vsync_o_n` is low for VS_LINES lines starting at line 1, and again for VS_LINES lines starting at line FIELD2_LINE. In slave mode, both outputs are held high.
- R6: A sync pair is detected at a clock edge where `vsync_in_n` was high at the previous edge, `vsync_in_n` is low now, and `hsync_in_n` is low now. Pairs are ignored when `slave_mode`=0 and `prog_in`=0, and a vertical edge while `hsync_in_n` is high is never a pair.
- R7: In slave mode with interlaced input (`prog_in`=0), the first pair after a reset or frame sync sets `line_cnt`=FIELD2_LINE and `pix_cnt`=1 at its edge. The next pair sets `line_cnt`=1 and `pix_cnt`=1 (odd field). The two actions alternate.
- R8: With `prog_in`=1, in either mode, the first pair leaves the counters advancing normally. The second pair sets `line_cnt`=1 and `pix_cnt`=1 (odd field). The two actions alternate.
- R9: `rst` and `soft_rst` clear the pair tracking, so the next pair after either one is treated as the first pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | One-cycle timing restart strobe |
| slave_mode | input | 1 | 1 = follow input syncs, 0 = generate syncs |
| fld_pol | input | 1 | Field indicator inversion |
| prog_in | input | 1 | 1 = progressive source frames |
| hsync_in_n | input | 1 | Incoming horizontal sync, active low |
| vsync_in_n | input | 1 | Incoming vertical sync, active low |
| field_o | output | 1 | Field indicator |
| line_cnt | output | LINE_W | Current line, 1-based |
| pix_cnt | output | PIX_W | Current pixel, 1-based |
| hsync_o_n | output | 1 | Generated horizontal sync, active low |
| vsync_o_n | output | 1 | Generated vertical sync, active low |

## Verification
A wrong pair-tracking bit does not show up until the next detected pair. At that pair, the counters jump to the wrong line (FIELD2_LINE instead of 1, or no jump at all), and `field_o` takes the wrong value in the same cycle. For this reason, the bench sends each of several pairs and compares the line and pixel counts exactly at the edge that consumes the pair. A counter or field-boundary fault shows at the ports on the first cycle it occurs, because every output is compared with a reference model on every clock.

// File: rtl/fld_pkg.sv
package fld_pkg;
  // action requested of the raster counters by the pair tracker
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_ODD  = 2'd1,
    LD_EVEN = 2'd2
  } load_e;
endpackage

// File: rtl/fld_pair_track.sv
module fld_pair_track
  import fld_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  soft_rst,
  input  logic  slave_mode,
  input  logic  prog_in,
  input  logic  hsync_in_n,
  input  logic  vsync_in_n,
  output load_e load_cmd
);
  logic vs_q;
  logic second_q;
  logic pair;

  assign pair = (slave_mode | prog_in) & vs_q & ~vsync_in_n & ~hsync_in_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q     <= 1'b1;
      second_q <= 1'b0;
    end else begin
      vs_q <= vsync_in_n;
      if (soft_rst)  second_q <= 1'b0;
      else if (pair) second_q <= ~second_q;
    end
  end

  always_comb begin
    load_cmd = LD_NONE;
    if (pair) begin
      if (second_q)      load_cmd = LD_ODD;
      else if (!prog_in) load_cmd = LD_EVEN;
    end
  end
endmodule

// File: rtl/fld_timebase.sv
module fld_timebase
  import fld_pkg::*;
#(
  parameter int LINE_PIXELS = 864,
  parameter int FRAME_LINES = 625,
  parameter int FIELD2_LINE = 313,
  localparam int PIX_W  = $clog2(LINE_PIXELS + 1),
  localparam int LINE_W = $clog2(FRAME_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  load_e             load_cmd,
  output logic [PIX_W-1:0]  pix_q,
  output logic [LINE_W-1:0] line_q,
  output logic [PIX_W-1:0]  pix_nxt,
  output logic [LINE_W-1:0] line_nxt
);
  localparam logic [PIX_W-1:0]  LP_L  = PIX_W'(LINE_PIXELS);
  localparam logic [LINE_W-1:0] FL_L  = LINE_W'(FRAME_LINES);
  localparam logic [LINE_W-1:0] F2_L  = LINE_W'(FIELD2_LINE);
  localparam logic [PIX_W-1:0]  ONE_P = PIX_W'(1);
  localparam logic [LINE_W-1:0] ONE_L = LINE_W'(1);

  always_comb begin
    pix_nxt  = pix_q;
    line_nxt = line_q;
    if (rst || soft_rst) begin
      pix_nxt  = ONE_P;
      line_nxt = ONE_L;
    end else begin
      unique case (load_cmd)
        LD_ODD: begin
          pix_nxt  = ONE_P;
          line_nxt = ONE_L;
        end
        LD_EVEN: begin
          pix_nxt  = ONE_P;
          line_nxt = F2_L;
        end
        default: begin
          if (pix_q == LP_L) begin
            pix_nxt  = ONE_P;
            line_nxt = (line_q == FL_L) ? ONE_L : line_q + ONE_L;
          end else begin
            pix_nxt = pix_q + ONE_P;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    pix_q  <= pix_nxt;
    line_q <= line_nxt;
  end
endmodule

// File: rtl/fld_outputs.sv
module fld_outputs #(
  parameter int FRAME_LINES = 625,
  parameter int LINE_PIXELS = 864,
  parameter int FIELD2_LINE = 313,
  parameter int HS_WIDTH    = 64,
  parameter int VS_LINES    = 3,
  localparam int PIX_W  = $clog2(LINE_PIXELS + 1),
  localparam int LINE_W = $clog2(FRAME_LINES + 1)
) (
  input  logic              clk,
  input  logic              slave_mode,
  input  logic              fld_pol,
  input  logic [PIX_W-1:0]  pix_nxt,
  input  logic [LINE_W-1:0] line_nxt,
  output logic              field_o,
  output logic              hsync_o_n,
  output logic              vsync_o_n
);
  localparam logic [LINE_W-1:0] F2_L    = LINE_W'(FIELD2_LINE);
  localparam logic [LINE_W-1:0] V1_END  = LINE_W'(VS_LINES);
  localparam logic [LINE_W-1:0] V2_END  = LINE_W'(FIELD2_LINE + VS_LINES - 1);
  localparam logic [PIX_W-1:0]  HS_END  = PIX_W'(HS_WIDTH);

  logic even_nxt, hs_win, vs_win;

  assign even_nxt = (line_nxt >= F2_L);
  assign hs_win   = (pix_nxt <= HS_END);
  assign vs_win   = (line_nxt <= V1_END) || ((line_nxt >= F2_L) && (line_nxt <= V2_END));

  always_ff @(posedge clk) begin
    field_o   <= even_nxt ^ fld_pol;
    hsync_o_n <= slave_mode | ~hs_win;
    vsync_o_n <= slave_mode | ~vs_win;
  end
endmodule

// File: rtl/fld_track_gen.sv
module fld_track_gen
  import fld_pkg::*;
#(
  parameter int LINE_PIXELS = 864,
  parameter int FRAME_LINES = 625,
  parameter int FIELD2_LINE = 313,
  parameter int HS_WIDTH    = 64,
  parameter int VS_LINES    = 3,
  localparam int PIX_W  = $clog2(LINE_PIXELS + 1),
  localparam int LINE_W = $clog2(FRAME_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              slave_mode,
  input  logic              fld_pol,
  input  logic              prog_in,
  input  logic              hsync_in_n,
  input  logic              vsync_in_n,
  output logic              field_o,
  output logic [LINE_W-1:0] line_cnt,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic              hsync_o_n,
  output logic              vsync_o_n
);
  load_e             load_cmd;
  logic [PIX_W-1:0]  pix_nxt;
  logic [LINE_W-1:0] line_nxt;

  fld_pair_track u_pair (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .slave_mode(slave_mode),
    .prog_in(prog_in), .hsync_in_n(hsync_in_n), .vsync_in_n(vsync_in_n),
    .load_cmd(load_cmd)
  );

  fld_timebase #(
    .LINE_PIXELS(LINE_PIXELS), .FRAME_LINES(FRAME_LINES), .FIELD2_LINE(FIELD2_LINE)
  ) u_tb (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .load_cmd(load_cmd),
    .pix_q(pix_cnt), .line_q(line_cnt), .pix_nxt(pix_nxt), .line_nxt(line_nxt)
  );

  fld_outputs #(
    .FRAME_LINES(FRAME_LINES), .LINE_PIXELS(LINE_PIXELS), .FIELD2_LINE(FIELD2_LINE),
    .HS_WIDTH(HS_WIDTH), .VS_LINES(VS_LINES)
  ) u_out (
    .clk(clk), .slave_mode(slave_mode), .fld_pol(fld_pol),
    .pix_nxt(pix_nxt), .line_nxt(line_nxt),
    .field_o(field_o), .hsync_o_n(hsync_o_n), .vsync_o_n(vsync_o_n)
  );
endmodule

// File: rtl/fld_track_chk.sv
module fld_track_chk #(
  parameter int LINE_PIXELS = 864,
  parameter int FRAME_LINES = 625,
  parameter int FIELD2_LINE = 313,
  localparam int PIX_W  = $clog2(LINE_PIXELS + 1),
  localparam int LINE_W = $clog2(FRAME_LINES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              slave_mode,
  input logic              fld_pol,
  input logic              prog_in,
  input logic              hsync_in_n,
  input logic              vsync_in_n,
  input logic              field_o,
  input logic [LINE_W-1:0] line_cnt,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic              hsync_o_n,
  input logic              vsync_o_n
);
  logic vs_seen;
  logic pair_seen;

  always_ff @(posedge clk) begin
    if (rst) vs_seen <= 1'b1;
    else     vs_seen <= vsync_in_n;
  end

  assign pair_seen = (slave_mode | prog_in) & vs_seen & ~vsync_in_n & ~hsync_in_n;

  p_pix_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && !pair_seen && pix_cnt != PIX_W'(LINE_PIXELS))
      |=> pix_cnt == $past(pix_cnt) + PIX_W'(1));

  p_pix_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!pair_seen && pix_cnt == PIX_W'(LINE_PIXELS)) |=> pix_cnt == PIX_W'(1));

  p_line_range_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (line_cnt >= LINE_W'(1) && line_cnt <= LINE_W'(FRAME_LINES)));

  p_soft_restart_r3: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (line_cnt == LINE_W'(1) && pix_cnt == PIX_W'(1)));

  p_field_sense_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> field_o == ((line_cnt >= LINE_W'(FIELD2_LINE)) ^ $past(fld_pol)));

  p_slave_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    slave_mode |=> (hsync_o_n && vsync_o_n));

  p_master_deaf_r6: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && !prog_in && !soft_rst && pix_cnt != PIX_W'(LINE_PIXELS))
      |=> pix_cnt == $past(pix_cnt) + PIX_W'(1));
endmodule

bind fld_track_gen fld_track_chk #(
  .LINE_PIXELS(LINE_PIXELS), .FRAME_LINES(FRAME_LINES), .FIELD2_LINE(FIELD2_LINE)
) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .slave_mode(slave_mode),
  .fld_pol(fld_pol), .prog_in(prog_in), .hsync_in_n(hsync_in_n),
  .vsync_in_n(vsync_in_n), .field_o(field_o), .line_cnt(line_cnt),
  .pix_cnt(pix_cnt), .hsync_o_n(hsync_o_n), .vsync_o_n(vsync_o_n)
);

// File: tb/tb_fld_track_gen.sv
module tb_fld_track_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LP  = 12;
  localparam int FL  = 11;
  localparam int F2  = 7;
  localparam int HSW = 3;
  localparam int VSL = 2;
  localparam int PIX_W  = $clog2(LP + 1);
  localparam int LINE_W = $clog2(FL + 1);

  logic clk = 1'b0;
  logic rst = 1'b1, soft_rst = 1'b0, slave_mode = 1'b0, fld_pol = 1'b0, prog_in = 1'b0;
  logic hsync_in_n = 1'b1, vsync_in_n = 1'b1;
  logic field_o, hsync_o_n, vsync_o_n;
  logic [LINE_W-1:0] line_cnt;
  logic [PIX_W-1:0]  pix_cnt;

  int tests = 0, fails = 0;
  bit done = 0;
  int el = 1, ep = 1;
  bit etog = 0, evs = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fld_track_gen #(.LINE_PIXELS(LP), .FRAME_LINES(FL), .FIELD2_LINE(F2),
                  .HS_WIDTH(HSW), .VS_LINES(VSL)) dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .slave_mode(slave_mode),
    .fld_pol(fld_pol), .prog_in(prog_in), .hsync_in_n(hsync_in_n),
    .vsync_in_n(vsync_in_n), .field_o(field_o), .line_cnt(line_cnt),
    .pix_cnt(pix_cnt), .hsync_o_n(hsync_o_n), .vsync_o_n(vsync_o_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    bit pair, xf, xh, xv;
    if (rst) begin
      el = 1; ep = 1; etog = 0; evs = 1;
    end else begin
      pair = (slave_mode || prog_in) && evs && !vsync_in_n && !hsync_in_n;
      if (soft_rst) begin el = 1; ep = 1; etog = 0; end
      else if (pair && etog) begin el = 1; ep = 1; etog = 0; end
      else if (pair && !prog_in) begin el = F2; ep = 1; etog = 1; end
      else begin
        if (pair) etog = 1;
        if (ep == LP) begin ep = 1; el = (el == FL) ? 1 : el + 1; end
        else ep = ep + 1;
      end
      evs = vsync_in_n;
    end
    xf = (el >= F2) ^ fld_pol;
    xh = slave_mode || !(ep <= HSW);
    xv = slave_mode || !((el <= VSL) || (el >= F2 && el <= F2 + VSL - 1));
    @(posedge clk);
    #1;
    check(line_cnt == el && pix_cnt == ep, "R2 line/pixel", int'(line_cnt)*1000 + int'(pix_cnt), el*1000 + ep);
    check(field_o == xf, "R1 field", int'(field_o), int'(xf));
    check(hsync_o_n == xh && vsync_o_n == xv, "R5 syncs", int'({hsync_o_n, vsync_o_n}), int'({xh, xv}));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pair_hit();
    hsync_in_n = 1'b0; vsync_in_n = 1'b0;
    tick();
  endtask

  task automatic pair_release();
    hsync_in_n = 1'b1; vsync_in_n = 1'b1;
    tick();
  endtask

  task automatic soft_restart();
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #2;
    run(3);
    check(line_cnt == 1 && pix_cnt == 1 && field_o == 1'b0, "R3 reset state", int'(line_cnt), 1);
    rst = 1'b0;
    // master, polarity 0, two frames
    run(2 * LP * FL + 5);
    while (!(line_cnt == F2 && pix_cnt == 1)) tick();
    check(field_o == 1'b1, "R4 even start high", int'(field_o), 1);
    check(hsync_o_n == 1'b0 && vsync_o_n == 1'b0, "R5 field2 syncs", int'({hsync_o_n, vsync_o_n}), 0);
    fld_pol = 1'b1; tick();
    check(field_o == 1'b0, "R1 inverted even", int'(field_o), 0);
    run(LP * FL);
    // soft restart mid-field
    run(17);
    soft_restart();
    check(line_cnt == 1 && pix_cnt == 1 && field_o == 1'b1, "R3 soft restart odd", int'(line_cnt), 1);
    fld_pol = 1'b0;
    // master, interlaced: pairs ignored
    run(9);
    pair_hit();
    check(line_cnt == el && line_cnt != F2, "R6 master ignores pair", int'(line_cnt), el);
    pair_release();
    // slave mode
    slave_mode = 1'b1;
    soft_restart();
    run(20);
    hsync_in_n = 1'b1; vsync_in_n = 1'b0; tick();
    check(line_cnt == el && pix_cnt == ep, "R6 vsync without hsync", int'(pix_cnt), ep);
    vsync_in_n = 1'b1; tick();
    pair_hit();
    check(line_cnt == F2 && pix_cnt == 1 && field_o == 1'b1, "R7 first pair even", int'(line_cnt), F2);
    check(hsync_o_n && vsync_o_n, "R5 slave syncs high", int'({hsync_o_n, vsync_o_n}), 3);
    pair_release();
    hsync_in_n = 1'b0; tick(); hsync_in_n = 1'b1;
    run(30);
    pair_hit();
    check(line_cnt == 1 && pix_cnt == 1 && field_o == 1'b0, "R7 second pair odd", int'(line_cnt), 1);
    pair_release();
    run(25);
    pair_hit();
    check(line_cnt == F2, "R7 third pair even", int'(line_cnt), F2);
    pair_release();
    run(LP * FL);
    // R9: soft restart clears tracking
    soft_restart();
    run(5);
    pair_hit();
    check(line_cnt == F2 && pix_cnt == 1, "R9 tracking cleared", int'(line_cnt), F2);
    pair_release();
    run(8);
    soft_rst = 1'b1; pair_hit(); soft_rst = 1'b0;
    check(line_cnt == 1 && pix_cnt == 1, "R3 soft beats pair", int'(line_cnt), 1);
    pair_release();
    run(6);
    pair_hit();
    check(line_cnt == F2, "R9 first after soft", int'(line_cnt), F2);
    pair_release();
    // progressive, master mode
    slave_mode = 1'b0; prog_in = 1'b1;
    soft_restart();
    run(40);
    pair_hit();
    check(line_cnt == el && line_cnt != 1 && line_cnt != F2, "R8 first frame no jump", int'(line_cnt), el);
    pair_release();
    run(50);
    pair_hit();
    check(line_cnt == 1 && pix_cnt == 1 && field_o == 1'b0, "R8 second frame odd", int'(line_cnt), 1);
    pair_release();
    run(LP * FL);
    // progressive, slave mode
    slave_mode = 1'b1;
    run(3);
    pair_hit();
    check(line_cnt == el && line_cnt != F2, "R8 slave prog first", int'(line_cnt), el);
    pair_release();
    run(60);
    pair_hit();
    check(line_cnt == 1 && pix_cnt == 1, "R8 slave prog second", int'(line_cnt), 1);
    pair_release();
    run(2 * LP * FL);
    done = 1;
    finish_run();
  end
endmodule